// File: doc/BRIEF.md
# Dual Warp Issue Scheduler

This block is the issue stage of one streaming multiprocessor. A warp is a bundle of 32 threads that all run the same instruction. The block holds two independent schedulers. The first one serves the even-numbered warps and the second one serves the odd-numbered warps. In every cycle each scheduler may pick at most one ready warp from its own pool and send that warp's next instruction to an execution group.

There are four execution groups:

- Two 16-lane core groups. Each scheduler owns one of them.
- One 16-lane load/store group, shared by both schedulers.
- One 4-lane special-function group, shared by both schedulers.

A 32-thread warp has to pass through a narrow group over several cycles. The block therefore keeps a busy counter for every group. A warp whose target group is busy is skipped, and its scheduler's round-robin pointer stays parked on it.

The surrounding pipeline supplies three things for each warp: a ready flag, the unit class of its next instruction, and its 32-bit active-lane mask. A divergent warp runs each branch path under its own mask, so a warp whose mask is all zero is never issued. The issue outputs are combinational from these inputs and the registered pointers and counters. The busy state they cause takes effect from the next clock edge.

Top module: `warp_issue_dual`

## Requirements
- R1: An active-low asynchronous reset clears every group's busy counter and both round-robin pointers to local slot 0. A warp that was blocked before reset can therefore issue in the first cycle after reset.
- R2: Scheduler 0 only issues even warps and scheduler 1 only issues odd warps. The issued warp number on the port is the global warp index, 4 bits per scheduler, with scheduler s in bits [4s+3:4s].
- R3: Each scheduler searches its pool in round-robin order, starting at its pointer. After a grant with no skipped warp ahead of it, the pointer moves to the slot after the granted warp. When there is no grant, the pointer stays where it is.
- R4: A warp issued to a 16-lane group (unit code 0 = core, 1 = load/store) keeps that group busy in the issue cycle and the next cycle. A new issue to that group is possible two cycles after the previous one.
- R5: A warp issued to the special-function group (unit code 2) keeps that group busy for 8 cycles, including the issue cycle.
- R6: Each scheduler has its own core group, so both schedulers can issue core instructions in the same cycle.
- R7: If both schedulers want the same shared group in one cycle, scheduler 0 gets it. Scheduler 1 may still issue a different warp whose group is free in that same cycle.
- R8: A ready warp whose target group is busy, or has just been taken by scheduler 0, is skipped. The pointer parks on the first such skipped warp, so that warp has priority once its group is free.
- R9: A warp whose 32-bit lane mask is all zero is never issued. The issued mask equals the chosen warp's mask, 32 bits per scheduler, with scheduler s in bits [32s+31:32s].
- R10: A warp whose unit class is the reserved code 3 is never issued.
- R11: When a scheduler does not issue, its valid bit is 0 and its warp, unit and mask fields are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | 16 | Ready flag of each warp |
| warp_class | input | 32 | Unit class of each warp's next instruction, 2 bits per warp |
| warp_mask | input | 512 | Active-lane mask of each warp, 32 bits per warp |
| issue_valid | output | 2 | Issue grant, one bit per scheduler |
| issue_warp | output | 8 | Global index of the issued warp, 4 bits per scheduler |
| issue_unit | output | 4 | Target unit code, 2 bits per scheduler |
| issue_mask | output | 64 | Active-lane mask of the issued instruction, 32 bits per scheduler |

## Verification
The assertions check several properties on every cycle:

- A group never receives an issue while its counter is still running.
- A 16-lane or special-function issue is always followed by a busy cycle.
- The two schedulers never claim the same shared group together.
- A granted warp was always ready, had a live mask and did not carry the reserved class.
- A scheduler's pointer stays put in any cycle without a grant.

The exact busy lengths of 2 and 8 cycles, the round-robin order with wrap-around, the parking of the pointer on a skipped warp and the priority of scheduler 0 are shown only by the bench's directed scenarios, because each depends on a sequence of cycles with known expected warps.

// File: rtl/wis_pkg.sv
package wis_pkg;

   typedef enum logic [1:0] {
      UNIT_CORE = 2'd0,
      UNIT_LDST = 2'd1,
      UNIT_SPEC = 2'd2,
      UNIT_NONE = 2'd3
   } unit_e;

   localparam int UNIT_BITS = 2;

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         req,
   input  logic [$clog2(N)-1:0] start,
   output logic                 hit,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   if (N < 2 || (1 << IW) != N) begin : g_bad_n
      $error("wis_rr_pick: N must be a power of two and at least 2");
   end

   always_comb begin : p_scan
      logic [IW-1:0] j;
      hit = 1'b0;
      idx = start;
      j   = start;
      for (int i = 0; i < N; i++) begin
         j = start + IW'(i);
         if (!hit && req[j]) begin
            hit = 1'b1;
            idx = j;
         end
      end
   end

endmodule

// File: rtl/wis_busy_ctr.sv
module wis_busy_ctr #(
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic idle
);
   localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

   if (HOLD < 1) begin : g_bad_hold
      $error("wis_busy_ctr: HOLD must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (start)       cnt <= CW'(HOLD - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign idle = (cnt == '0);

   // A group is only ever started while it is free.
   assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> idle);

   if (HOLD > 1) begin : g_hold_chk
      // A multi-cycle issue leaves the group busy on the next cycle.
      assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
         start |=> !idle);
      // The group only becomes busy because of an issue.
      assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(idle) |-> $past(start));
   end

endmodule

// File: rtl/wis_sched.sv
module wis_sched
   import wis_pkg::*;
#(
   parameter int POOL = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [POOL-1:0]         ready,
   input  logic [2*POOL-1:0]       cls,
   input  logic [POOL-1:0]         live,
   input  logic                    core_idle,
   input  logic                    ldst_idle,
   input  logic                    spec_idle,
   output logic                    grant,
   output logic [$clog2(POOL)-1:0] gidx,
   output logic [1:0]              gunit
);
   localparam int PW = $clog2(POOL);

   logic [POOL-1:0] cand;
   logic [POOL-1:0] unit_ok;
   logic [POOL-1:0] elig;
   logic [PW-1:0]   ptr;
   logic            c_hit;
   logic [PW-1:0]   c_idx;

   always_comb begin
      for (int i = 0; i < POOL; i++) begin
         cand[i] = ready[i] && live[i] && (cls[2*i +: 2] != UNIT_NONE);
         case (unit_e'(cls[2*i +: 2]))
            UNIT_CORE: unit_ok[i] = core_idle;
            UNIT_LDST: unit_ok[i] = ldst_idle;
            UNIT_SPEC: unit_ok[i] = spec_idle;
            default:   unit_ok[i] = 1'b0;
         endcase
      end
   end

   assign elig = cand & unit_ok;

   wis_rr_pick #(.N(POOL)) u_cand_pick (
      .req(cand), .start(ptr), .hit(c_hit), .idx(c_idx)
   );

   wis_rr_pick #(.N(POOL)) u_elig_pick (
      .req(elig), .start(ptr), .hit(grant), .idx(gidx)
   );

   assign gunit = grant ? cls[2*gidx +: 2] : 2'd0;

   // Park on the first skipped warp; otherwise step past the granted one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (grant && c_hit) ptr <= (c_idx == gidx) ? gidx + PW'(1) : c_idx;
   end

   assert_grant_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (ready[gidx] && live[gidx]));

   assert_no_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (gunit != UNIT_NONE));

   assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |=> $stable(ptr));

   assert_spec_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && gunit == UNIT_SPEC) |-> spec_idle);

endmodule

// File: rtl/warp_issue_dual.sv
module warp_issue_dual
   import wis_pkg::*;
#(
   parameter int NUM_WARPS  = 16,
   parameter int LANES      = 32,
   parameter int CORE_WIDTH = 16,
   parameter int LDST_WIDTH = 16,
   parameter int SPEC_WIDTH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_WARPS-1:0]   warp_ready,
   input  logic [2*NUM_WARPS-1:0] warp_class,
   input  logic [NUM_WARPS*LANES-1:0] warp_mask,
   output logic [1:0]             issue_valid,
   output logic [2*$clog2(NUM_WARPS)-1:0] issue_warp,
   output logic [3:0]             issue_unit,
   output logic [2*LANES-1:0]     issue_mask
);
   localparam int POOL      = NUM_WARPS / 2;
   localparam int WW        = $clog2(NUM_WARPS);
   localparam int PW        = $clog2(POOL);
   localparam int CORE_HOLD = LANES / CORE_WIDTH;
   localparam int LDST_HOLD = LANES / LDST_WIDTH;
   localparam int SPEC_HOLD = LANES / SPEC_WIDTH;

   if (NUM_WARPS < 4 || (1 << WW) != NUM_WARPS) begin : g_bad_warps
      $error("warp_issue_dual: NUM_WARPS must be a power of two, at least 4");
   end
   if (LANES % CORE_WIDTH != 0 || LANES % LDST_WIDTH != 0 ||
       LANES % SPEC_WIDTH != 0) begin : g_bad_width
      $error("warp_issue_dual: unit widths must divide LANES");
   end

   logic [1:0]          grant;
   logic [1:0][PW-1:0]  gidx;
   logic [1:0][1:0]     gunit;
   logic [1:0]          core_idle;
   logic                ldst_idle;
   logic                spec_idle;
   logic [NUM_WARPS-1:0] live;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_live
      assign live[w] = |warp_mask[w*LANES +: LANES];
   end

   for (genvar s = 0; s < 2; s++) begin : g_sched
      logic [POOL-1:0]   ready_s;
      logic [2*POOL-1:0] cls_s;
      logic [POOL-1:0]   live_s;
      logic              ldst_ok;
      logic              spec_ok;
      logic [WW-1:0]     gw;

      for (genvar i = 0; i < POOL; i++) begin : g_pool
         assign ready_s[i]       = warp_ready[2*i + s];
         assign cls_s[2*i +: 2]  = warp_class[2*(2*i + s) +: 2];
         assign live_s[i]        = live[2*i + s];
      end

      if (s == 0) begin : g_first
         assign ldst_ok = ldst_idle;
         assign spec_ok = spec_idle;
      end else begin : g_second
         // Scheduler 0 has already claimed its shared group this cycle.
         assign ldst_ok = ldst_idle && !(grant[0] && gunit[0] == UNIT_LDST);
         assign spec_ok = spec_idle && !(grant[0] && gunit[0] == UNIT_SPEC);
      end

      wis_sched #(.POOL(POOL)) u_sched (
         .clk(clk), .rst_n(rst_n),
         .ready(ready_s), .cls(cls_s), .live(live_s),
         .core_idle(core_idle[s]), .ldst_idle(ldst_ok), .spec_idle(spec_ok),
         .grant(grant[s]), .gidx(gidx[s]), .gunit(gunit[s])
      );

      wis_busy_ctr #(.HOLD(CORE_HOLD)) u_core_busy (
         .clk(clk), .rst_n(rst_n),
         .start(grant[s] && gunit[s] == UNIT_CORE),
         .idle(core_idle[s])
      );

      assign gw = {gidx[s], 1'(s)};
      assign issue_valid[s]          = grant[s];
      assign issue_warp[s*WW +: WW]  = grant[s] ? gw : '0;
      assign issue_unit[s*2 +: 2]    = grant[s] ? gunit[s] : 2'd0;
      assign issue_mask[s*LANES +: LANES] =
         grant[s] ? warp_mask[int'(gw)*LANES +: LANES] : '0;
   end

   wis_busy_ctr #(.HOLD(LDST_HOLD)) u_ldst_busy (
      .clk(clk), .rst_n(rst_n),
      .start((grant[0] && gunit[0] == UNIT_LDST) || (grant[1] && gunit[1] == UNIT_LDST)),
      .idle(ldst_idle)
   );

   wis_busy_ctr #(.HOLD(SPEC_HOLD)) u_spec_busy (
      .clk(clk), .rst_n(rst_n),
      .start((grant[0] && gunit[0] == UNIT_SPEC) || (grant[1] && gunit[1] == UNIT_SPEC)),
      .idle(spec_idle)
   );

   // Two issues never land on the same shared group in one cycle.
   assert_shared_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid == 2'b11 && issue_unit[1:0] != UNIT_CORE)
         |-> (issue_unit[1:0] != issue_unit[3:2]));

endmodule

// File: tb/warp_issue_dual_tb.sv
module warp_issue_dual_tb;
   localparam int NW = 16;
   localparam int LN = 32;
   localparam int WW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NW-1:0]   warp_ready;
   logic [2*NW-1:0] warp_class;
   logic [NW*LN-1:0] warp_mask;
   logic [1:0]      issue_valid;
   logic [2*WW-1:0] issue_warp;
   logic [3:0]      issue_unit;
   logic [2*LN-1:0] issue_mask;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   warp_issue_dual u_dut (
      .clk(clk), .rst_n(rst_n),
      .warp_ready(warp_ready), .warp_class(warp_class), .warp_mask(warp_mask),
      .issue_valid(issue_valid), .issue_warp(issue_warp),
      .issue_unit(issue_unit), .issue_mask(issue_mask)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic expect_issue(int s, bit v, int w, int u, logic [31:0] m, string req);
      chk(req, $sformatf("sched%0d valid", s), 32'(issue_valid[s]), 32'(v));
      chk(req, $sformatf("sched%0d warp", s),  32'(issue_warp[s*WW +: WW]), v ? w : 0);
      chk(req, $sformatf("sched%0d unit", s),  32'(issue_unit[s*2 +: 2]), v ? u : 0);
      chk(req, $sformatf("sched%0d mask", s),  issue_mask[s*LN +: LN], v ? m : 32'h0);
   endtask

   task automatic set_warp(int w, bit rdy, logic [1:0] cls, logic [31:0] m);
      warp_ready[w]         = rdy;
      warp_class[2*w +: 2]  = cls;
      warp_mask[w*LN +: LN] = m;
   endtask

   task automatic clear_all();
      warp_ready = '0;
      warp_class = '0;
      warp_mask  = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clear_all();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
   endtask

   task automatic next_cyc();
      @(negedge clk);
      #2;
   endtask

   task automatic settle();
      #1;
   endtask

   // R1, R2, R3, R4, R6, R11
   task automatic test_reset_and_cores();
      do_reset();
      settle();
      expect_issue(0, 0, 0, 0, 0, "R11");
      expect_issue(1, 0, 0, 0, 0, "R11");
      for (int w = 0; w < NW; w++) set_warp(w, 1, 2'd0, 32'hFFFF_FFFF);
      settle();
      expect_issue(0, 1, 0, 0, 32'hFFFF_FFFF, "R1");
      expect_issue(1, 1, 1, 0, 32'hFFFF_FFFF, "R6");
      next_cyc();
      expect_issue(0, 0, 0, 0, 0, "R4");
      expect_issue(1, 0, 0, 0, 0, "R4");
      next_cyc();
      expect_issue(0, 1, 2, 0, 32'hFFFF_FFFF, "R3");
      expect_issue(1, 1, 3, 0, 32'hFFFF_FFFF, "R2");
   endtask

   // R3, R2: round-robin with wrap over a sparse ready set
   task automatic test_round_robin();
      do_reset();
      set_warp(2, 1, 2'd0, 32'h1234_5678);
      set_warp(6, 1, 2'd0, 32'h0000_FFFF);
      set_warp(10, 1, 2'd0, 32'h8000_0000);
      settle();
      expect_issue(0, 1, 2, 0, 32'h1234_5678, "R3");
      expect_issue(1, 0, 0, 0, 0, "R2");
      next_cyc(); next_cyc();
      expect_issue(0, 1, 6, 0, 32'h0000_FFFF, "R3");
      next_cyc(); next_cyc();
      expect_issue(0, 1, 10, 0, 32'h8000_0000, "R3");
      next_cyc(); next_cyc();
      expect_issue(0, 1, 2, 0, 32'h1234_5678, "R3_wrap");
   endtask

   // R4, R5, R1: busy lengths and reset of a running counter
   task automatic test_busy_lengths();
      do_reset();
      set_warp(0, 1, 2'd2, 32'hFFFF_FFFF);
      set_warp(2, 1, 2'd2, 32'hFFFF_FFFF);
      set_warp(1, 1, 2'd1, 32'hFFFF_FFFF);
      set_warp(3, 1, 2'd1, 32'hFFFF_FFFF);
      settle();
      expect_issue(0, 1, 0, 2, 32'hFFFF_FFFF, "R5");
      expect_issue(1, 1, 1, 1, 32'hFFFF_FFFF, "R4");
      next_cyc();
      expect_issue(0, 0, 0, 0, 0, "R5");
      expect_issue(1, 0, 0, 0, 0, "R4");
      next_cyc();
      expect_issue(1, 1, 3, 1, 32'hFFFF_FFFF, "R4");
      for (int c = 3; c <= 7; c++) begin
         next_cyc();
         chk("R5", $sformatf("spec still busy cycle %0d", c), 32'(issue_valid[0]), 32'd0);
      end
      next_cyc();
      expect_issue(0, 1, 2, 2, 32'hFFFF_FFFF, "R5");
      next_cyc();
      chk("R5", "spec busy after reissue", 32'(issue_valid[0]), 32'd0);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      expect_issue(0, 1, 0, 2, 32'hFFFF_FFFF, "R1");
   endtask

   // R7, R8: shared-group priority and pointer parking
   task automatic test_conflict_and_park();
      do_reset();
      set_warp(0, 1, 2'd1, 32'hFFFF_FFFF);
      set_warp(1, 1, 2'd1, 32'h0F0F_0F0F);
      set_warp(3, 1, 2'd0, 32'hFFFF_FFFF);
      set_warp(5, 1, 2'd0, 32'hFFFF_FFFF);
      settle();
      expect_issue(0, 1, 0, 1, 32'hFFFF_FFFF, "R7");
      expect_issue(1, 1, 3, 0, 32'hFFFF_FFFF, "R7");
      next_cyc();
      expect_issue(0, 0, 0, 0, 0, "R8");
      expect_issue(1, 0, 0, 0, 0, "R8");
      set_warp(0, 0, 2'd1, 32'hFFFF_FFFF);
      next_cyc();
      expect_issue(1, 1, 1, 1, 32'h0F0F_0F0F, "R8");
      expect_issue(0, 0, 0, 0, 0, "R8");
   endtask

   // R9, R10, R11: empty masks and reserved class
   task automatic test_mask_and_reserved();
      do_reset();
      set_warp(0, 1, 2'd0, 32'h0);
      set_warp(2, 1, 2'd0, 32'hA5A5_0F0F);
      set_warp(1, 1, 2'd3, 32'hFFFF_FFFF);
      set_warp(3, 1, 2'd0, 32'h0000_0001);
      settle();
      expect_issue(0, 1, 2, 0, 32'hA5A5_0F0F, "R9");
      expect_issue(1, 1, 3, 0, 32'h0000_0001, "R10");
      set_warp(2, 0, 2'd0, 32'hA5A5_0F0F);
      set_warp(3, 0, 2'd0, 32'h0000_0001);
      next_cyc(); next_cyc();
      expect_issue(0, 0, 0, 0, 0, "R9");
      expect_issue(1, 0, 0, 0, 0, "R10");
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      clear_all();
      test_reset_and_cores();
      test_round_robin();
      test_busy_lengths();
      test_conflict_and_park();
      test_mask_and_reserved();
      done = 1;
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

endmodule